// File: doc/BRIEF.md
# Accumulator ALU with Shared-Bus Strobes

This block holds an accumulator and a data register side by side with an eight-operation arithmetic/logic unit. All three sit on one internal data bus. A sequencer outside the block issues four strobes: capture the bus into the data register, capture the bus into the accumulator, place the ALU result on the bus, and place the accumulator on the bus. A 3-bit select code picks the operation. The codes match the low opcodes of the processor that hosts the block, so an add instruction holds the select at 1 for its whole execute sequence.

A result reaches the accumulator only by way of the bus. The sequencer loads the data register, drives the ALU result, and loads the accumulator on a later clock. The ALU is purely combinational on the registered values. When the result is driven and captured on the same edge, the accumulator takes the value computed from the registers as they stood before that edge. The block reports that it is driving the bus only when exactly one of its two drive enables is high.

Top module: `acc_alu_bus`

## Requirements
- R1: An active-low asynchronous reset (`rstN`) clears the accumulator and the data register to 0x00.
- R2: The data register takes `busIn` on a rising clock edge when `mdrLoad` is high, and holds its value otherwise.
- R3: The accumulator takes `busIn` on a rising clock edge when `accLoad` is high, and holds its value otherwise.
- R4: With `accDrive` high and `aluDrive` low, `busDrive` is 1 and `busOut` equals the accumulator.
- R5: With `aluDrive` alone high, select 0 drives the accumulator plus one and select 3 drives the accumulator minus one, both wrapping modulo 256 (0xFF+1 gives 0x00, 0x00-1 gives 0xFF).
- R6: Select 1 drives accumulator plus data register and select 2 drives accumulator minus data register (never the reverse), both modulo 256, with no carry or flag output.
- R7: Select 4 drives the bitwise complement of the accumulator, whatever the data register holds.
- R8: Select 5 drives accumulator AND data register, select 6 drives OR, and select 7 drives XOR.
- R9: With neither drive enable high, `busDrive` is 0 and `busOut` is 0x00. Both enables high together is a contention fault that an assertion flags.
- R10: When the ALU result is driven and loaded into a register on the same edge, that register receives the result computed from the pre-edge register values. A staged add (load data register, then drive and load the accumulator) leaves the sum in the accumulator.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| busIn | input | 8 | Value present on the shared data bus |
| mdrLoad | input | 1 | Capture bus into data register |
| aluDrive | input | 1 | Place ALU result on the bus |
| accLoad | input | 1 | Capture bus into accumulator |
| accDrive | input | 1 | Place accumulator on the bus |
| opSel | input | 3 | ALU operation select (0 inc, 1 add, 2 sub, 3 dec, 4 not, 5 and, 6 or, 7 xor) |
| busOut | output | 8 | Value the block drives onto the bus, 0 when idle |
| busDrive | output | 1 | High when the block drives the bus |

## Verification
The hardest case to reach from the ports is a register capturing a value that the block itself is driving, on the same edge that changes the operands. It proves that the loaded value comes from the old register contents. The bench closes the bus loop: `busIn` follows `busOut` whenever `busDrive` is high, and comes from a modelled memory value otherwise. Random strobe mixes then often drive the ALU while loading the accumulator or the data register. Directed sequences cover the staged add, the wrap points of increment, decrement, add and subtract, and complement with several data-register values.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
  localparam int DATA_W = 8;
  localparam int SEL_W  = 3;

  typedef enum logic [SEL_W-1:0] {
    OP_INC = 3'd0,
    OP_ADD = 3'd1,
    OP_SUB = 3'd2,
    OP_DEC = 3'd3,
    OP_NOT = 3'd4,
    OP_AND = 3'd5,
    OP_OR  = 3'd6,
    OP_XOR = 3'd7
  } aluOpT;

  typedef struct packed {
    logic mdrWe;
    logic accWe;
    logic pickAlu;
    logic driveEn;
  } strobeT;
endpackage

// File: rtl/acc_alu_ctrl.sv
module acc_alu_ctrl
  import acc_alu_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   mdrLoad,
  input  logic   aluDrive,
  input  logic   accLoad,
  input  logic   accDrive,
  output strobeT strobes
);
  always_comb begin
    strobes.mdrWe   = mdrLoad;
    strobes.accWe   = accLoad;
    strobes.pickAlu = aluDrive;
    strobes.driveEn = aluDrive ^ accDrive;
  end

  // R9: both enables at once is bus contention
  p_no_contention_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({aluDrive, accDrive}));
endmodule

// File: rtl/acc_alu_unit.sv
module acc_alu_unit
  import acc_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [SEL_W-1:0] opSel,
  input  logic [W-1:0]     accVal,
  input  logic [W-1:0]     mdrVal,
  output logic [W-1:0]     result
);
  localparam logic [W-1:0] ONE = W'(1);

  aluOpT op;
  assign op = aluOpT'(opSel);

  always_comb begin
    unique case (op)
      OP_INC:  result = accVal + ONE;
      OP_ADD:  result = accVal + mdrVal;
      OP_SUB:  result = accVal - mdrVal;
      OP_DEC:  result = accVal - ONE;
      OP_NOT:  result = ~accVal;
      OP_AND:  result = accVal & mdrVal;
      OP_OR:   result = accVal | mdrVal;
      default: result = accVal ^ mdrVal;
    endcase
  end
endmodule

// File: rtl/acc_alu_core.sv
module acc_alu_core
  import acc_alu_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [W-1:0]     busIn,
  input  logic [SEL_W-1:0] opSel,
  input  strobeT           strobes,
  output logic [W-1:0]     busOut
);
  logic [W-1:0] accReg;
  logic [W-1:0] mdrReg;
  logic [W-1:0] aluResult;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      accReg <= '0;
      mdrReg <= '0;
    end else begin
      if (strobes.accWe) accReg <= busIn;
      if (strobes.mdrWe) mdrReg <= busIn;
    end
  end

  acc_alu_unit #(.W(W)) u_unit (
    .opSel  (opSel),
    .accVal (accReg),
    .mdrVal (mdrReg),
    .result (aluResult)
  );

  always_comb begin
    if (!strobes.driveEn)     busOut = '0;
    else if (strobes.pickAlu) busOut = aluResult;
    else                      busOut = accReg;
  end

  p_acc_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.accWe |=> accReg == $past(busIn));
  p_acc_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.accWe |=> $stable(accReg));
  p_mdr_load_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.mdrWe |=> mdrReg == $past(busIn));
  p_mdr_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.mdrWe |=> $stable(mdrReg));
  p_idle_zero_r9: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.driveEn |-> busOut == '0);
endmodule

// File: rtl/acc_alu_bus.sv
module acc_alu_bus
  import acc_alu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] busIn,
  input  logic              mdrLoad,
  input  logic              aluDrive,
  input  logic              accLoad,
  input  logic              accDrive,
  input  logic [SEL_W-1:0]  opSel,
  output logic [DATA_W-1:0] busOut,
  output logic              busDrive
);
  strobeT strobes;

  acc_alu_ctrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .mdrLoad  (mdrLoad),
    .aluDrive (aluDrive),
    .accLoad  (accLoad),
    .accDrive (accDrive),
    .strobes  (strobes)
  );

  acc_alu_core #(.W(DATA_W)) u_core (
    .clk     (clk),
    .rstN    (rstN),
    .busIn   (busIn),
    .opSel   (opSel),
    .strobes (strobes),
    .busOut  (busOut)
  );

  assign busDrive = strobes.driveEn;

  // R4: an accumulator-only drive always reports a driven bus
  p_acc_drive_r4: assert property (@(posedge clk) disable iff (!rstN)
    (accDrive && !aluDrive) |-> busDrive);
endmodule

// File: tb/acc_alu_bus_bench.sv
module acc_alu_bus_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] romData = 8'h00;
  logic       mdrLoad = 0, aluDrive = 0, accLoad = 0, accDrive = 0;
  logic [2:0] opSel = 3'd0;
  logic [7:0] busOut, busIn;
  logic       busDrive;
  int         total = 0, bad = 0;
  logic [7:0] mAcc = 8'h00, mMdr = 8'h00;
  bit         finished = 0;

  always #2 clk = ~clk;

  assign busIn = busDrive ? busOut : romData;

  acc_alu_bus u_acc_alu_bus (
    .clk(clk), .rstN(rstN), .busIn(busIn), .mdrLoad(mdrLoad),
    .aluDrive(aluDrive), .accLoad(accLoad), .accDrive(accDrive),
    .opSel(opSel), .busOut(busOut), .busDrive(busDrive)
  );

  function automatic logic [7:0] expAlu(input logic [2:0] op,
                                        input logic [7:0] a,
                                        input logic [7:0] m);
    case (op)
      3'd0: return a + 8'd1;
      3'd1: return a + m;
      3'd2: return a - m;
      3'd3: return a - 8'd1;
      3'd4: return ~a;
      3'd5: return a & m;
      3'd6: return a | m;
      default: return a ^ m;
    endcase
  endfunction

  function automatic string reqOf(input logic alu, input logic acc,
                                  input logic [2:0] op);
    if (alu == acc) return "R9";
    if (acc) return "R4";
    case (op)
      3'd0, 3'd3: return "R5";
      3'd1, 3'd2: return "R6";
      3'd4: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req, input logic [8:0] act,
                       input logic [8:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one bus cycle: apply strobes, check outputs, let the edge happen, update model
  task automatic cycle(input logic ld, input logic ad, input logic al,
                       input logic dd, input logic [2:0] op,
                       input logic [7:0] rom, input string tag);
    logic [7:0] expOut, busVal;
    logic       expDrv;
    @(negedge clk);
    mdrLoad = ld; aluDrive = ad; accLoad = al; accDrive = dd;
    opSel = op; romData = rom;
    #1;
    expDrv = ad ^ dd;
    expOut = !expDrv ? 8'h00 : (ad ? expAlu(op, mAcc, mMdr) : mAcc);
    check(tag.len() ? tag : reqOf(ad, dd, op), {expDrv, busOut},
          {expDrv, expOut});
    check(tag.len() ? tag : reqOf(ad, dd, op), {1'b0, busDrive},
          {1'b0, expDrv});
    busVal = expDrv ? expOut : rom;
    @(posedge clk);
    if (al) mAcc = busVal;
    if (ld) mMdr = busVal;
  endtask

  task automatic setRegs(input logic [7:0] a, input logic [7:0] m);
    cycle(1, 0, 1, 0, 3'd0, a, "R3");
    cycle(1, 0, 0, 0, 3'd0, m, "R2");
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_1234));
    accDrive = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", {1'b0, busOut}, 9'h000);   // reset: acc reads 0
    rstN = 1;
    cycle(0, 0, 0, 1, 3'd0, 8'h00, "R1");  // acc still 0 after reset
    cycle(0, 1, 0, 0, 3'd0, 8'h00, "R1");  // 0 + 1 with cleared regs
    cycle(0, 1, 0, 0, 3'd1, 8'h00, "R1");  // mdr cleared: 0 + 0

    // R5 wrap points
    setRegs(8'hFF, 8'h33);
    cycle(0, 1, 0, 0, 3'd0, 8'h00, "R5");
    setRegs(8'h00, 8'h33);
    cycle(0, 1, 0, 0, 3'd3, 8'h00, "R5");
    // R6 add wrap and subtract order
    setRegs(8'hF0, 8'h20);
    cycle(0, 1, 0, 0, 3'd1, 8'h00, "R6");
    setRegs(8'h03, 8'h05);
    cycle(0, 1, 0, 0, 3'd2, 8'h00, "R6");
    // R7 complement ignores mdr
    setRegs(8'hA5, 8'h00);
    cycle(0, 1, 0, 0, 3'd4, 8'h00, "R7");
    cycle(1, 0, 0, 0, 3'd0, 8'hFF, "R2");
    cycle(0, 1, 0, 0, 3'd4, 8'h00, "R7");
    // R8 logic
    setRegs(8'hCC, 8'hAA);
    for (int k = 5; k < 8; k++) cycle(0, 1, 0, 0, 3'(k), 8'h00, "R8");
    // R2/R3 hold without strobe, R9 idle
    cycle(0, 0, 0, 0, 3'd1, 8'h5A, "R9");
    cycle(0, 0, 0, 1, 3'd0, 8'h00, "R3");
    cycle(0, 1, 0, 0, 3'd1, 8'h00, "R2");
    // R10 staged add: load mdr, then drive ALU and load acc together
    setRegs(8'h10, 8'h00);
    cycle(1, 0, 0, 0, 3'd1, 8'h22, "R10");
    cycle(0, 1, 1, 0, 3'd1, 8'h00, "R10");
    cycle(0, 0, 0, 1, 3'd1, 8'h00, "R10");
    check("R10", {1'b0, mAcc}, 9'h032);
    // R10 result into mdr as well
    cycle(1, 1, 0, 0, 3'd3, 8'h00, "R10");
    cycle(0, 1, 0, 0, 3'd5, 8'h00, "R10");

    // random mix, never both drive enables
    for (int i = 0; i < 3000; i++) begin
      logic [2:0] drv;
      drv = 3'($urandom_range(0, 2));
      cycle(1'($urandom), drv == 1, 1'($urandom), drv == 2,
            3'($urandom), 8'($urandom), "");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule